// File: doc/BRIEF.md
# Descriptor Admission Checker

This block sits behind a descriptor fetch engine in a multi-channel DMA. The engine streams one fixed-size descriptor of sixteen 32-bit words into the checker, one word per accepted beat. A beat is accepted when `in_valid` is high. The engine marks the final beat with `in_last`. The checker decides whether the channel may execute the descriptor. It reports one verdict that carries a prioritised error code. The verdict also carries the decoded control flags, the packed status word the channel exposes, and an indication that the descriptor chain stops here.

Word 0 is the control word. Word 5 carries the completion mark in its top bit. Word 15 holds an optional additive checksum over words 0 to 14. The checks run in a fixed order, and only the first one that fails is reported. When the last-word flag does not line up with word 15, the checker reports a framing fault instead of judging the contents.

Top module: `desc_check_top`

## Requirements
- R1: `res_valid` pulses high for exactly one cycle. The pulse comes in the cycle after the beat that closes a descriptor. A beat closes a descriptor when it is the 16th word or when `in_last` is high. Idle cycles inside a descriptor do not disturb the word count.
- R2: If bits 7:0 of word 0 differ from 0xA5, the verdict is code 1 (bad preamble).
- R3: When control bit 20 is set, the modulo-2^32 sum of words 0 to 14 must equal word 15, otherwise the verdict is code 2 (checksum). When bit 20 is clear, word 15 has no effect on the verdict.
- R4: If bit 31 of word 5 is set and control bit 10 is clear, the verdict is code 3 (already done). With bit 10 set, the mark is ignored.
- R5: Priority of codes: framing (4) over preamble (1) over checksum (2) over already done (3). Code 0 means the descriptor may run.
- R6: If `in_last` arrives before the 16th word, or the 16th word arrives without `in_last`, the verdict is code 4. In that case `res_flags` and `res_status` are zero, and the next beat starts a new descriptor.
- R7: `res_flags` holds these control bits: bit 0 is done-interrupt enable (control bit 8), bit 1 is write-back enable (9), bit 2 is fixed burst (11), bit 3 is fragmented mode (18), bit 4 is last descriptor (19), and bit 5 is last of frame (21).
- R8: `res_status` places control bits 7:0 at bits 20:13. Bit 12 is control bit 8 and bit 11 is control bit 9. Bit 10 is the completion mark. Bit 9 is control bit 10 and bit 8 is control bit 21. Bit 7 is control bit 19 and bit 6 is control bit 20. Bit 5 is control bit 18 and bit 4 is control bit 11. All other bits are zero.
- R9: `res_chain_end` is high when the verdict is an error, or when control bit 19 or bit 21 is set.
- R10: The checksum accumulator restarts with every descriptor, so back-to-back descriptors are judged independently. This also holds after a framing fault.
- R11: After reset, `res_valid` is low and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor word present this cycle |
| in_word | input | 32 | Descriptor word |
| in_last | input | 1 | Final word of the descriptor |
| res_valid | output | 1 | Verdict pulse |
| res_err | output | 3 | Verdict code (0 ok, 1 preamble, 2 checksum, 3 done, 4 framing) |
| res_flags | output | 6 | Decoded control flags |
| res_status | output | 32 | Packed channel status word |
| res_chain_end | output | 1 | Chain stops after this descriptor |

## Verification
The bench feeds descriptors that fail several checks at once. A design that checks in the wrong order would then report a lower-priority code. Descriptors with a wrong word 15 but checksum disabled are also sent, to catch a design that checks unconditionally. Framing faults are sent from both sides, a short descriptor and a 16-word one without the last flag. Each is followed by a checksum-protected descriptor, which exposes a counter or accumulator that fails to restart. Idle gaps inside a descriptor and back-to-back descriptors expose a counter that advances without a beat or a verdict issued in the wrong cycle.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam logic [7:0]  PREAMBLE  = 8'hA5;

    localparam int unsigned CB_IRQ    = 8;
    localparam int unsigned CB_WB     = 9;
    localparam int unsigned CB_IGN    = 10;
    localparam int unsigned CB_FIXED  = 11;
    localparam int unsigned CB_FRAG   = 18;
    localparam int unsigned CB_LAST   = 19;
    localparam int unsigned CB_SUM    = 20;
    localparam int unsigned CB_LFRAME = 21;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        V_OK       = 3'd0,
        V_PREAMBLE = 3'd1,
        V_CHECKSUM = 3'd2,
        V_DONE     = 3'd3,
        V_FRAMING  = 3'd4
    } verdict_e;

    // Bit 0 is the interrupt enable, bit 5 last-of-frame.
    typedef struct packed {
        logic lframe;
        logic last;
        logic frag;
        logic fixed;
        logic wb;
        logic irq;
    } flags_t;

    function automatic flags_t decode_flags(input word_t c);
        flags_t f;
        f.lframe = c[CB_LFRAME];
        f.last   = c[CB_LAST];
        f.frag   = c[CB_FRAG];
        f.fixed  = c[CB_FIXED];
        f.wb     = c[CB_WB];
        f.irq    = c[CB_IRQ];
        return f;
    endfunction

    function automatic word_t pack_status(input word_t c, input logic done);
        word_t s;
        s        = '0;
        s[20:13] = c[7:0];
        s[12]    = c[CB_IRQ];
        s[11]    = c[CB_WB];
        s[10]    = done;
        s[9]     = c[CB_IGN];
        s[8]     = c[CB_LFRAME];
        s[7]     = c[CB_LAST];
        s[6]     = c[CB_SUM];
        s[5]     = c[CB_FRAG];
        s[4]     = c[CB_FIXED];
        return s;
    endfunction

endpackage

// File: rtl/desc_seq.sv
module desc_seq
    import desc_chk_pkg::*;
#(
    parameter int unsigned N_WORDS    = 16,
    parameter int unsigned STAMP_WORD = 5,
    localparam int unsigned IDX_W     = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  word_t            in_word,
    input  logic             in_last,
    output logic [IDX_W-1:0] idx,
    output logic             end_beat,
    output logic             full_ok,
    output word_t            ctrl_q,
    output logic             done_q
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_WORDS - 1);
    localparam logic [IDX_W-1:0] STAMP_IDX = IDX_W'(STAMP_WORD);

    logic at_final;

    assign at_final = (idx == LAST_IDX);
    assign end_beat = in_valid && (in_last || at_final);
    assign full_ok  = in_last && at_final;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            ctrl_q <= '0;
            done_q <= 1'b0;
        end else if (in_valid) begin
            idx <= end_beat ? '0 : idx + 1'b1;
            if (idx == '0)
                ctrl_q <= in_word;
            if (idx == STAMP_IDX)
                done_q <= in_word[WORD_W-1];
        end
    end

    // R1: a cycle without a beat leaves the word position untouched
    assert_hold_idx_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(idx));

endmodule

// File: rtl/desc_sum.sv
module desc_sum
    import desc_chk_pkg::*;
#(
    parameter int unsigned N_WORDS = 16,
    localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] idx,
    input  word_t            in_word,
    output logic             sum_match
);

    word_t acc;

    // The first word of every descriptor reloads the accumulator.
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (in_valid)
            acc <= (idx == '0) ? in_word : acc + in_word;
    end

    assign sum_match = (acc == in_word);

endmodule

// File: rtl/desc_judge.sv
module desc_judge
    import desc_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     end_beat,
    input  logic     full_ok,
    input  word_t    ctrl,
    input  logic     done,
    input  logic     sum_match,
    output logic     res_valid,
    output verdict_e res_err,
    output flags_t   res_flags,
    output word_t    res_status,
    output logic     res_chain_end
);

    verdict_e v_d;
    flags_t   f_d;
    word_t    s_d;
    logic     chain_d;

    always_comb begin
        if (!full_ok)
            v_d = V_FRAMING;
        else if (ctrl[7:0] != PREAMBLE)
            v_d = V_PREAMBLE;
        else if (ctrl[CB_SUM] && !sum_match)
            v_d = V_CHECKSUM;
        else if (done && !ctrl[CB_IGN])
            v_d = V_DONE;
        else
            v_d = V_OK;
        f_d     = full_ok ? decode_flags(ctrl) : '0;
        s_d     = full_ok ? pack_status(ctrl, done) : '0;
        chain_d = (v_d != V_OK) || f_d.last || f_d.lframe;
    end

    always_ff @(posedge clk) begin
        if (rst || !end_beat) begin
            res_valid     <= 1'b0;
            res_err       <= V_OK;
            res_flags     <= '0;
            res_status    <= '0;
            res_chain_end <= 1'b0;
        end else begin
            res_valid     <= 1'b1;
            res_err       <= v_d;
            res_flags     <= f_d;
            res_status    <= s_d;
            res_chain_end <= chain_d;
        end
    end

endmodule

// File: rtl/desc_check_top.sv
module desc_check_top
    import desc_chk_pkg::*;
#(
    parameter int unsigned N_WORDS    = 16,
    parameter int unsigned STAMP_WORD = 5,
    localparam int unsigned IDX_W     = $clog2(N_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        in_last,
    output logic        res_valid,
    output logic [2:0]  res_err,
    output logic [5:0]  res_flags,
    output logic [31:0] res_status,
    output logic        res_chain_end
);

    logic [IDX_W-1:0] idx;
    logic             end_beat, full_ok, done_q, sum_match;
    word_t            ctrl_q;
    verdict_e         verdict;
    flags_t           flags;

    desc_seq #(.N_WORDS(N_WORDS), .STAMP_WORD(STAMP_WORD)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_last(in_last), .idx(idx), .end_beat(end_beat),
        .full_ok(full_ok), .ctrl_q(ctrl_q), .done_q(done_q)
    );

    desc_sum #(.N_WORDS(N_WORDS)) u_sum (
        .clk(clk), .rst(rst), .in_valid(in_valid), .idx(idx),
        .in_word(in_word), .sum_match(sum_match)
    );

    desc_judge u_judge (
        .clk(clk), .rst(rst), .end_beat(end_beat), .full_ok(full_ok),
        .ctrl(ctrl_q), .done(done_q), .sum_match(sum_match),
        .res_valid(res_valid), .res_err(verdict), .res_flags(flags),
        .res_status(res_status), .res_chain_end(res_chain_end)
    );

    assign res_err   = verdict;
    assign res_flags = flags;

    // R1: a verdict only follows an accepted beat
    assert_pulse_src_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));

    // R2: an accepted descriptor carries the expected preamble
    assert_preamble_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err == 3'd0) |-> (res_status[20:13] == 8'hA5));

    // R3: a checksum verdict requires checksum enable
    assert_sum_en_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err == 3'd2) |-> res_status[6]);

    // R4: a done verdict requires the mark without the override
    assert_done_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err == 3'd3) |-> (res_status[10] && !res_status[9]));

    // R6: framing faults report no decoded content
    assert_framing_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err == 3'd4) |-> (res_status == '0 && res_flags == '0));

    // R9: any error stops the chain
    assert_chain_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err != 3'd0) |-> res_chain_end);

endmodule

// File: tb/tb_desc_check_top.sv
module tb_desc_check_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        res_valid, res_chain_end;
    logic [2:0]  res_err;
    logic [5:0]  res_flags;
    logic [31:0] res_status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [2:0]  err;
        logic [5:0]  flags;
        logic [31:0] status;
        logic        chain;
        int          at;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t e;

    localparam logic [31:0] PRE   = 32'h0000_00A5;
    localparam logic [31:0] IRQ   = 32'h1 << 8;
    localparam logic [31:0] WB    = 32'h1 << 9;
    localparam logic [31:0] IGN   = 32'h1 << 10;
    localparam logic [31:0] FIX   = 32'h1 << 11;
    localparam logic [31:0] FRAG  = 32'h1 << 18;
    localparam logic [31:0] LST   = 32'h1 << 19;
    localparam logic [31:0] CSUM  = 32'h1 << 20;
    localparam logic [31:0] LFR   = 32'h1 << 21;

    desc_check_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_last(in_last), .res_valid(res_valid), .res_err(res_err),
        .res_flags(res_flags), .res_status(res_status),
        .res_chain_end(res_chain_end)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic mk(output logic [31:0] w [16], input logic [31:0] ctrl,
                      input bit done, input logic [31:0] seed, input bit good_sum);
        logic [31:0] s;
        w[0] = ctrl;
        for (int i = 1; i < 15; i++)
            w[i] = seed * (i + 3) ^ (32'(i) << 20) ^ 32'h9E37_0000;
        w[5] = done ? (w[5] | 32'h8000_0000) : (w[5] & 32'h7FFF_FFFF);
        s = '0;
        for (int i = 0; i < 15; i++) s = s + w[i];
        w[15] = good_sum ? s : s + 32'd1;
    endtask

    task automatic send(input logic [31:0] w [16], input int n, input bit lastf,
                        input int gap, input string tag);
        exp_t x;
        logic [31:0] c, s;
        c = w[0];
        x.tag = tag;
        if (!(n == 16 && lastf)) begin
            x.err = 3'd4; x.flags = '0; x.status = '0; x.chain = 1'b1;
        end else begin
            s = '0;
            for (int i = 0; i < 15; i++) s = s + w[i];
            if (c[7:0] != 8'hA5)                    x.err = 3'd1;
            else if (c[20] && s != w[15])           x.err = 3'd2;
            else if (w[5][31] && !c[10])            x.err = 3'd3;
            else                                    x.err = 3'd0;
            x.flags  = {c[21], c[19], c[18], c[11], c[9], c[8]};
            x.status = '0;
            x.status[20:13] = c[7:0];
            x.status[12] = c[8];  x.status[11] = c[9];
            x.status[10] = w[5][31]; x.status[9] = c[10];
            x.status[8] = c[21];  x.status[7] = c[19];
            x.status[6] = c[20];  x.status[5] = c[18];
            x.status[4] = c[11];
            x.chain = (x.err != 3'd0) || c[19] || c[21];
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = w[i];
            in_last  = lastf && (i == n - 1);
            if (i == n - 1) begin
                x.at = cyc + 1;
                sb.push_back(x);
            end else if (gap > 0 && i == 6) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_last  = 1'b0;
                end
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected verdict: actual err=%0d expected none", res_err);
            end else begin
                e = sb.pop_front();
                if (res_err !== e.err || res_flags !== e.flags ||
                    res_status !== e.status || res_chain_end !== e.chain ||
                    cyc != e.at) begin
                    fails++;
                    $display("FAIL %s: actual err=%0d flags=%h status=%h chain=%b cyc=%0d expected err=%0d flags=%h status=%h chain=%b cyc=%0d",
                             e.tag, res_err, res_flags, res_status, res_chain_end, cyc,
                             e.err, e.flags, e.status, e.chain, e.at);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w [16];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_err !== 3'd0 || res_status !== '0 ||
            res_flags !== '0 || res_chain_end !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: actual valid=%b err=%0d status=%h expected 0 0 0",
                     res_valid, res_err, res_status);
        end

        mk(w, PRE | IRQ | FIX, 1'b0, 32'h1111, 1'b1);  send(w, 16, 1, 0, "R7 R8 plain ok");
        idle(2);
        mk(w, 32'h0000_00A4 | WB, 1'b0, 32'h2222, 1'b1); send(w, 16, 1, 0, "R2 bad preamble");
        idle(1);
        mk(w, PRE | CSUM | FRAG, 1'b0, 32'h3333, 1'b1);  send(w, 16, 1, 3, "R3 R1 sum good with gap");
        mk(w, PRE | CSUM, 1'b0, 32'h4444, 1'b0);         send(w, 16, 1, 0, "R3 sum bad");
        mk(w, PRE | WB, 1'b0, 32'h5555, 1'b0);           send(w, 16, 1, 0, "R3 sum disabled ignored");
        idle(1);
        mk(w, PRE | IRQ, 1'b1, 32'h6666, 1'b1);          send(w, 16, 1, 0, "R4 already done");
        mk(w, PRE | IGN | WB, 1'b1, 32'h7777, 1'b1);     send(w, 16, 1, 0, "R4 done ignored");
        mk(w, 32'h0000_005A | CSUM, 1'b1, 32'h8888, 1'b0); send(w, 16, 1, 0, "R5 preamble first");
        mk(w, PRE | CSUM, 1'b1, 32'h9999, 1'b0);         send(w, 16, 1, 0, "R5 sum before done");
        idle(2);
        mk(w, PRE | CSUM, 1'b0, 32'hAAAA, 1'b1);         send(w, 8, 1, 0, "R6 short framing");
        mk(w, PRE | CSUM | IRQ, 1'b0, 32'hBBBB, 1'b1);   send(w, 16, 1, 0, "R10 after short");
        mk(w, PRE | CSUM, 1'b0, 32'hCCCC, 1'b1);         send(w, 16, 0, 0, "R6 missing last");
        mk(w, PRE | CSUM | FIX, 1'b0, 32'hDDDD, 1'b1);   send(w, 16, 1, 0, "R10 after missing last");
        mk(w, PRE | LST | CSUM, 1'b0, 32'hFFFF_FFF1, 1'b1); send(w, 16, 1, 0, "R9 R10 last desc");
        mk(w, PRE | LFR | FRAG, 1'b0, 32'h0F0F, 1'b1);   send(w, 16, 1, 0, "R9 last of frame");
        idle(6);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 missing verdicts: actual %0d pending expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule